// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block collects 256 edge-triggered device interrupt lines for one node, records each rising edge in a sticky pending bit, and steers pending, enabled vectors onto per-core interrupt pins. Routing has two levels. A byte per group of 32 vectors picks one CPU interrupt pin. A byte per vector picks a one-hot set of cores inside the node and names a destination node. Only vectors whose node field matches this node's identifier drive the local outputs.

Software reaches every register through a simple 32-bit word bus with a combinational read path. Handlers read a status word and write the same value back to acknowledge it. Retargeting a vector is done in three steps: clear its enable bit, rewrite its route byte, then set the enable bit again. A single global enable bit must be set before any output can assert.

Top module: `eio_router`

## Requirements
- R1: After reset every register reads zero, the global enable is off and all `irq_out` bits are low.
- R2: A rising edge on `irq_in[n]` sets the pending bit of vector n, which reads at 32-bit address 0x1800 + (n>>5)*4, bit n&31 (so 64-bit status word n/64 holds it at bit n%64). An input held high sets it only once.
- R3: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A rising edge in the same cycle as the clear wins and the bit stays set.
- R4: Status reads return raw pending bits whatever the enable bits hold; enable bits only gate the outputs.
- R5: The enable bit of vector v is at 0x1600 + (v>>5)*4, bit v&31. A pending vector with a clear enable bit drives no output.
- R6: The pin-map byte of group g (vectors 32g to 32g+31) is byte g&3 of the word at 0x14C0 + (g>>2)*4. Bit p of that byte routes the group to pin p.
- R7: The route byte of vector v is byte v&3 of the word at 0x1C00 + (v>>2)*4. Bits 3:0 are a one-hot core mask and bits 7:4 the destination node; a vector drives local outputs only when that node equals `NODE_ID`.
- R8: The global enable is bit 0 of the word at 0x1000. While it is clear, all outputs stay low.
- R9: The node-map words at 0x14A0 and the bounce words at 0x1680 read back what was written and have no effect on the outputs.
- R10: `irq_out[c*NUM_PINS + p]` is high when any enabled pending vector has its group mapped to pin p and its route selecting core c on this node.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 256 | Device interrupt lines, rising-edge sensitive |
| bus_we | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | 13 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 32 | Interrupt lines, index core*NUM_PINS + pin |

## Verification
The hardest situation to reach from the ports is a fresh rising edge arriving in exactly the cycle that software acknowledges the same vector. The bench first leaves the line low after a recorded edge, then raises it on the same falling edge at which it drives the status write, so both land on one rising clock edge. A vector whose route names another node and a pending vector whose enable bit is clear are also built on purpose, so that status and outputs disagree in a way the ports can show.

// File: rtl/eio_pkg.sv
package eio_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_GLOB    = 13'h1000;
  localparam logic [ADDR_W-1:0] A_NODEMAP = 13'h14A0;
  localparam logic [ADDR_W-1:0] A_PINMAP  = 13'h14C0;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 13'h1600;
  localparam logic [ADDR_W-1:0] A_BOUNCE  = 13'h1680;
  localparam logic [ADDR_W-1:0] A_STATUS  = 13'h1800;
  localparam logic [ADDR_W-1:0] A_ROUTE   = 13'h1C00;

  // True when addr is word aligned and falls inside [base, base + 4*words)
  function automatic logic in_window(logic [ADDR_W-1:0] addr,
                                     logic [ADDR_W-1:0] base,
                                     int unsigned words);
    return (addr[1:0] == 2'b00) && (32'(addr) >= 32'(base)) &&
           (32'(addr) < 32'(base) + words * 4);
  endfunction

  function automatic int unsigned word_idx(logic [ADDR_W-1:0] addr,
                                           logic [ADDR_W-1:0] base);
    return (32'(addr) - 32'(base)) >> 2;
  endfunction
endpackage

// File: rtl/eio_edge_latch.sv
module eio_edge_latch #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_in,
  input  logic [NUM_VEC-1:0] clr,
  output logic [NUM_VEC-1:0] status
);
  logic [NUM_VEC-1:0] prev_q, status_q, status_d, rise;

  always_comb begin
    rise     = irq_in & ~prev_q;
    // a fresh edge overrides a same-cycle clear
    status_d = (status_q & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= irq_in;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != '0) |=> ((status_q & $past(clr & ~rise)) == '0));
endmodule

// File: rtl/eio_cfg_regs.sv
module eio_cfg_regs
  import eio_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    glob_en,
  output logic [NUM_VEC-1:0]      nodemap,
  output logic [NUM_VEC/4-1:0]    pinmap,
  output logic [NUM_VEC-1:0]      enable,
  output logic [NUM_VEC-1:0]      bounce,
  output logic [NUM_VEC*8-1:0]    route
);
  localparam int unsigned NUM_GRP  = NUM_VEC / 32;
  localparam int unsigned PM_WORDS = NUM_GRP / 4;
  localparam int unsigned RT_WORDS = NUM_VEC / 4;

  logic                 glob_q, glob_d;
  logic [NUM_VEC-1:0]   nodemap_q, nodemap_d, enable_q, enable_d, bounce_q, bounce_d;
  logic [NUM_VEC/4-1:0] pinmap_q, pinmap_d;
  logic [NUM_VEC*8-1:0] route_q, route_d;

  always_comb begin
    glob_d    = glob_q;
    nodemap_d = nodemap_q;
    enable_d  = enable_q;
    bounce_d  = bounce_q;
    pinmap_d  = pinmap_q;
    route_d   = route_q;
    if (wr_en) begin
      if (in_window(addr, A_GLOB, 1)) glob_d = wdata[0];
      for (int unsigned w = 0; w < NUM_GRP; w++) begin
        if (in_window(addr, A_NODEMAP, NUM_GRP) && word_idx(addr, A_NODEMAP) == w)
          nodemap_d[w*32 +: 32] = wdata;
        if (in_window(addr, A_ENABLE, NUM_GRP) && word_idx(addr, A_ENABLE) == w)
          enable_d[w*32 +: 32] = wdata;
        if (in_window(addr, A_BOUNCE, NUM_GRP) && word_idx(addr, A_BOUNCE) == w)
          bounce_d[w*32 +: 32] = wdata;
      end
      for (int unsigned w = 0; w < PM_WORDS; w++)
        if (in_window(addr, A_PINMAP, PM_WORDS) && word_idx(addr, A_PINMAP) == w)
          pinmap_d[w*32 +: 32] = wdata;
      for (int unsigned w = 0; w < RT_WORDS; w++)
        if (in_window(addr, A_ROUTE, RT_WORDS) && word_idx(addr, A_ROUTE) == w)
          route_d[w*32 +: 32] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q    <= 1'b0;
      nodemap_q <= '0;
      enable_q  <= '0;
      bounce_q  <= '0;
      pinmap_q  <= '0;
      route_q   <= '0;
    end else if (wr_en) begin
      glob_q    <= glob_d;
      nodemap_q <= nodemap_d;
      enable_q  <= enable_d;
      bounce_q  <= bounce_d;
      pinmap_q  <= pinmap_d;
      route_q   <= route_d;
    end
  end

  assign glob_en = glob_q;
  assign nodemap = nodemap_q;
  assign enable  = enable_q;
  assign bounce  = bounce_q;
  assign pinmap  = pinmap_q;
  assign route   = route_q;
endmodule

// File: rtl/eio_route_fabric.sv
module eio_route_fabric #(
  parameter int unsigned NUM_VEC   = 256,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 8,
  parameter logic [3:0]  NODE_ID   = 4'd0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          glob_en,
  input  logic [NUM_VEC-1:0]            status,
  input  logic [NUM_VEC-1:0]            enable,
  input  logic [NUM_VEC/4-1:0]          pinmap,
  input  logic [NUM_VEC*8-1:0]          route,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_out
);
  localparam int unsigned NUM_GRP = NUM_VEC / 32;

  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] local_vec;
  logic [NUM_GRP-1:0] pin_grp [NUM_PINS];

  always_comb begin
    pend = status & enable;
    for (int unsigned v = 0; v < NUM_VEC; v++)
      local_vec[v] = (route[v*8+4 +: 4] == NODE_ID);
    for (int unsigned p = 0; p < NUM_PINS; p++)
      for (int unsigned g = 0; g < NUM_GRP; g++)
        pin_grp[p][g] = pinmap[g*8+p];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_VEC-1:0] hit;
    logic [NUM_GRP-1:0] grp_any;
    always_comb begin
      for (int unsigned v = 0; v < NUM_VEC; v++)
        hit[v] = route[v*8+c] & local_vec[v];
      for (int unsigned g = 0; g < NUM_GRP; g++)
        grp_any[g] = |(pend[g*32 +: 32] & hit[g*32 +: 32]);
      for (int unsigned p = 0; p < NUM_PINS; p++)
        irq_out[c*NUM_PINS+p] = glob_en & |(grp_any & pin_grp[p]);
    end
  end

  // R8
  glob_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (irq_out == '0));

  // R5
  no_pend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |-> (irq_out == '0));
endmodule

// File: rtl/eio_router.sv
module eio_router
  import eio_pkg::*;
#(
  parameter int unsigned NUM_VEC   = 256,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 8,
  parameter logic [3:0]  NODE_ID   = 4'd0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_VEC-1:0]            irq_in,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_out
);
  localparam int unsigned NUM_GRP  = NUM_VEC / 32;
  localparam int unsigned PM_WORDS = NUM_GRP / 4;
  localparam int unsigned RT_WORDS = NUM_VEC / 4;

  logic                 glob_en;
  logic [NUM_VEC-1:0]   nodemap, enable, bounce, status, clr;
  logic [NUM_VEC/4-1:0] pinmap;
  logic [NUM_VEC*8-1:0] route;

  always_comb begin
    clr = '0;
    if (bus_we && in_window(bus_addr, A_STATUS, NUM_GRP))
      for (int unsigned w = 0; w < NUM_GRP; w++)
        if (word_idx(bus_addr, A_STATUS) == w) clr[w*32 +: 32] = bus_wdata;
  end

  eio_edge_latch #(.NUM_VEC(NUM_VEC)) u_latch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(clr), .status(status)
  );

  eio_cfg_regs #(.NUM_VEC(NUM_VEC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .glob_en(glob_en), .nodemap(nodemap), .pinmap(pinmap), .enable(enable),
    .bounce(bounce), .route(route)
  );

  eio_route_fabric #(.NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS),
                     .NODE_ID(NODE_ID)) u_fabric (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .status(status), .enable(enable),
    .pinmap(pinmap), .route(route), .irq_out(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_window(bus_addr, A_GLOB, 1)) bus_rdata = {31'd0, glob_en};
    for (int unsigned w = 0; w < NUM_GRP; w++) begin
      if (in_window(bus_addr, A_NODEMAP, NUM_GRP) && word_idx(bus_addr, A_NODEMAP) == w)
        bus_rdata = nodemap[w*32 +: 32];
      if (in_window(bus_addr, A_ENABLE, NUM_GRP) && word_idx(bus_addr, A_ENABLE) == w)
        bus_rdata = enable[w*32 +: 32];
      if (in_window(bus_addr, A_BOUNCE, NUM_GRP) && word_idx(bus_addr, A_BOUNCE) == w)
        bus_rdata = bounce[w*32 +: 32];
      if (in_window(bus_addr, A_STATUS, NUM_GRP) && word_idx(bus_addr, A_STATUS) == w)
        bus_rdata = status[w*32 +: 32];
    end
    for (int unsigned w = 0; w < PM_WORDS; w++)
      if (in_window(bus_addr, A_PINMAP, PM_WORDS) && word_idx(bus_addr, A_PINMAP) == w)
        bus_rdata = pinmap[w*32 +: 32];
    for (int unsigned w = 0; w < RT_WORDS; w++)
      if (in_window(bus_addr, A_ROUTE, RT_WORDS) && word_idx(bus_addr, A_ROUTE) == w)
        bus_rdata = route[w*32 +: 32];
  end
endmodule

// File: tb/eio_router_bench.sv
module eio_router_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] irq_in = '0;
  logic         bus_we = 1'b0;
  logic [12:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [31:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  eio_router u_eio_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // {vector, pin, core, node}
  localparam logic [31:0] TBL [6] = '{
    32'h00_01_00_00, 32'h25_02_01_00, 32'h64_07_03_00,
    32'hFF_00_02_00, 32'h82_04_01_01, 32'h40_03_03_00
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); irq_in[v] = 1'b1;
    @(negedge clk); irq_in[v] = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(13'h1000, d);  chk(d == 0, "R1 glob", d, 0);
    rd(13'h1600, d);  chk(d == 0, "R1 enable", d, 0);
    rd(13'h1C00, d);  chk(d == 0, "R1 route", d, 0);
    rd(13'h1800, d);  chk(d == 0, "R1 status", d, 0);
    chk(irq_out == 0, "R1 out", irq_out, 0);

    wr(13'h1000, 32'd1);
    // R10 R6 R7 table walk
    for (int i = 0; i < 6; i++) begin
      int v, p, c, nd, g;
      logic [31:0] exp;
      v = int'(TBL[i][31:24]); p = int'(TBL[i][23:16]);
      c = int'(TBL[i][15:8]);  nd = int'(TBL[i][7:0]);
      g = v >> 5;
      exp = (nd == 0) ? (32'd1 << (c*8 + p)) : 32'd0;
      wr(13'(32'h14C0 + (g >> 2) * 4), (32'd1 << p) << (8 * (g & 3)));
      wr(13'(32'h1C00 + (v >> 2) * 4), (32'(nd << 4) | (32'd1 << c)) << (8 * (v & 3)));
      wr(13'(32'h1600 + g * 4), 32'd1 << (v & 31));
      pulse(v);
      @(negedge clk);
      chk(irq_out == exp, "R10 R7 R6 route", irq_out, exp);
      rd(13'(32'h1800 + g * 4), d);
      chk(d == (32'd1 << (v & 31)), "R2 status bit", d, 32'd1 << (v & 31));
      wr(13'(32'h1800 + g * 4), d);
      rd(13'(32'h1800 + g * 4), d);
      chk(d == 0 && irq_out == 0, "R3 clear", {d[15:0], irq_out[15:0]}, 0);
      wr(13'(32'h14C0 + (g >> 2) * 4), 0);
      wr(13'(32'h1C00 + (v >> 2) * 4), 0);
      wr(13'(32'h1600 + g * 4), 0);
    end

    // common setup: vector 5 -> pin 0, core 0
    wr(13'h14C0, 32'h01);
    wr(13'h1C04, 32'h0000_0100);
    // R4 R5: pending but disabled
    pulse(5);
    @(negedge clk);
    rd(13'h1800, d);
    chk(d == 32'h20, "R4 raw status", d, 32'h20);
    chk(irq_out == 0, "R5 masked out", irq_out, 0);
    wr(13'h1600, 32'h20);
    @(negedge clk);
    chk(irq_out == 32'h1, "R5 unmasked out", irq_out, 32'h1);
    // R8: global off
    wr(13'h1000, 0);
    @(negedge clk);
    chk(irq_out == 0, "R8 global off", irq_out, 0);
    wr(13'h1000, 1);
    @(negedge clk);
    chk(irq_out == 32'h1, "R8 global on", irq_out, 32'h1);

    // R3: edge in the same cycle as the clear wins
    @(negedge clk);
    irq_in[5] = 1'b1; bus_we = 1'b1; bus_addr = 13'h1800; bus_wdata = 32'h20;
    @(negedge clk);
    bus_we = 1'b0; irq_in[5] = 1'b0;
    rd(13'h1800, d);
    chk(d == 32'h20, "R3 edge beats clear", d, 32'h20);
    // R2: held level sets once
    @(negedge clk); irq_in[5] = 1'b1;
    wr(13'h1800, 32'h20);
    repeat (3) @(negedge clk);
    rd(13'h1800, d);
    chk(d == 0, "R2 held level no reset", d, 0);
    chk(irq_out == 0, "R2 held level out", irq_out, 0);
    irq_in[5] = 1'b0;

    // R9: node map and bounce are plain storage
    pulse(5);
    wr(13'h14A4, 32'hA5A5_0F0F);
    wr(13'h169C, 32'h1234_5678);
    rd(13'h14A4, d);
    chk(d == 32'hA5A5_0F0F, "R9 nodemap", d, 32'hA5A5_0F0F);
    rd(13'h169C, d);
    chk(d == 32'h1234_5678, "R9 bounce", d, 32'h1234_5678);
    chk(irq_out == 32'h1, "R9 out unaffected", irq_out, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule